// File: doc/BRIEF.md
# Fixed-Point Biquad Section with Residue Feedback

This block is one second-order recursive filter section in fixed point. On every accepted input strobe it takes a 16-bit signed sample and forms a direct-form-I sum over the current input, two delayed inputs and two delayed outputs. It then requantises that sum to a 26-bit internal state and returns a 16-bit output sample a fixed number of cycles later. One shared multiplier is reused over five multiply-accumulate steps, and a small state machine sequences them. The states are `ST_IDLE`, `ST_MAC` and `ST_QUANT`. The transitions are: `ST_IDLE -> ST_MAC` on an accepted strobe; `ST_MAC -> ST_MAC` while the tap index is below 4; `ST_MAC -> ST_QUANT` after tap 4; and `ST_QUANT -> ST_IDLE` unconditionally.

A mode bit, sampled with each input strobe, picks how the accumulator is reduced to state width. In plain truncation the low bits are thrown away. In fraction saving those low bits are kept in a residue register and start the next sample's accumulation, so the quantisation error is spectrally shaped rather than lost. Five 24-bit coefficients are written through a small register write port. Two sections can be chained by wiring `out_sample`/`out_valid` of one to `in_sample`/`in_valid` of the next.

Top module: `iir2_section`

## Requirements
- R1: A synchronous active-high reset clears the delay registers, the state, the residue, all five coefficients, `out_valid` and `out_sample`.
- R2: A write with `cfg_we` high loads `cfg_data` into the coefficient selected by `cfg_addr`: 0 feed-forward 0, 1 feed-forward 1, 2 feed-forward 2, 3 feedback 1, 4 feedback 2. Writes to addresses 5 to 7 change nothing.
- R3: Coefficients are signed 24-bit with 22 fractional bits. The state has 10 fractional bits below the input LSB. The full-precision sum is `res + c0*X0 + c1*X1 + c2*X2 - c3*Y1 - c4*Y2`. Here X is the input scaled by 1024 and Y is the raw 26-bit state. The sum is formed without overflow.
- R4: The new state is the sum shifted right arithmetically by 22, which is floor division. It replaces the first output delay, and the old one moves to the second. The input delays shift in the same step.
- R5: With `mode_save` high at the strobe, the stored residue is added into the sum. The low 22 bits of the sum, read as an unsigned value, are then stored as the new residue.
- R6: With `mode_save` low at the strobe, no residue is added and the residue register is left at zero.
- R7: `out_sample` is the new state shifted right arithmetically by 10, which is floor division.
- R8: `out_valid` is a one-cycle pulse that rises exactly 6 clock edges after the edge that accepts a strobe.
- R9: A strobe that arrives while a sample is in progress (any state other than idle) is ignored and produces no output.
- R10: If the shifted sum exceeds the 26-bit signed range, the state clamps to +33554431 or -33554432 and the residue is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| mode_save | input | 1 | 1 = fraction saving, 0 = truncation; sampled with the strobe |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 3 | Coefficient select |
| cfg_data | input | 24 | Signed coefficient value |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed output sample |

## Verification
The properties assume that the reset is applied once at the start and held for at least one edge. They also assume that strobes are spaced so that each accepted sample finishes before the next is taken; any strobe falling inside a busy window must leave no trace. The stimulus keeps to this by holding at least ten idle cycles between accepted strobes. On purpose, it raises a second strobe with a different sample and opposite mode in the middle of each busy window. Coefficient writes are issued only while the section is idle, because the datapath reads the bank continuously during the accumulation steps.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MAC   = 2'd1,
        ST_QUANT = 2'd2
    } iir2_state_e;

    // five products: three feed-forward then two feedback
    localparam int unsigned TAP_COUNT = 5;
    localparam int unsigned TAP_FB0   = 3;

endpackage

// File: rtl/iir2_coef_bank.sv
module iir2_coef_bank #(
    parameter int unsigned COEF_W = 24,
    parameter int unsigned N      = 5,
    parameter int unsigned AW     = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic signed [COEF_W-1:0]   wdata,
    output logic [N*COEF_W-1:0]        coef_flat
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic signed [COEF_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (we && (addr == AW'(g))) begin
                slot_q <= wdata;
            end
        end

        assign coef_flat[g*COEF_W +: COEF_W] = slot_q;
    end

endmodule

// File: rtl/iir2_mac.sv
module iir2_mac #(
    parameter int unsigned OP_W      = 26,
    parameter int unsigned COEF_W    = 24,
    parameter int unsigned ACC_W     = 53,
    parameter bit          MUL_SPLIT = 1'b1
) (
    input  logic signed [OP_W-1:0]   operand,
    input  logic signed [COEF_W-1:0] coef,
    input  logic                     subtract,
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [ACC_W-1:0]  acc_out
);

    localparam int unsigned PROD_W = OP_W + COEF_W;
    localparam int unsigned LO_W   = 17;
    localparam int unsigned HI_W   = COEF_W - LO_W;
    localparam int unsigned PH_W   = OP_W + HI_W;
    localparam int unsigned PL_W   = OP_W + LO_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    if (MUL_SPLIT) begin : g_split
        // coefficient cut into a signed upper slice and an unsigned lower slice
        logic signed [PH_W-1:0] p_hi;
        logic signed [PL_W-1:0] p_lo;
        logic signed [HI_W-1:0] c_hi;
        logic signed [LO_W:0]   c_lo;

        assign c_hi = coef[COEF_W-1:LO_W];
        assign c_lo = {1'b0, coef[LO_W-1:0]};
        assign p_hi = PH_W'(operand) * PH_W'(c_hi);
        assign p_lo = PL_W'(operand) * PL_W'(c_lo);
        assign prod = (PROD_W'(p_hi) <<< LO_W) + PROD_W'(p_lo);
    end else begin : g_flat
        assign prod = PROD_W'(operand) * PROD_W'(coef);
    end

    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign acc_out  = subtract ? (acc_in - prod_ext) : (acc_in + prod_ext);

endmodule

// File: rtl/iir2_requant.sv
module iir2_requant #(
    parameter int unsigned ACC_W = 53,
    parameter int unsigned ST_W  = 26,
    parameter int unsigned CF    = 22
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [ST_W-1:0]  state_q,
    output logic [CF-1:0]           resid_q,
    output logic                    sat
);

    localparam int unsigned HI_W = ACC_W - CF;

    logic [HI_W-1:0] hi;
    logic            ovf_pos;
    logic            ovf_neg;

    assign hi      = acc[ACC_W-1:CF];
    assign ovf_pos = !hi[HI_W-1] &&  (|hi[HI_W-2:ST_W-1]);
    assign ovf_neg =  hi[HI_W-1] && !(&hi[HI_W-2:ST_W-1]);
    assign sat     = ovf_pos || ovf_neg;
    assign resid_q = acc[CF-1:0];

    always_comb begin
        if (ovf_pos) begin
            state_q = {1'b0, {(ST_W-1){1'b1}}};
        end else if (ovf_neg) begin
            state_q = {1'b1, {(ST_W-1){1'b0}}};
        end else begin
            state_q = hi[ST_W-1:0];
        end
    end

endmodule

// File: rtl/iir2_section.sv
module iir2_section
    import iir2_pkg::*;
#(
    parameter int unsigned IN_W      = 16,
    parameter int unsigned COEF_W    = 24,
    parameter int unsigned ST_W      = 26,
    parameter int unsigned CFG_AW    = 3,
    parameter bit          MUL_SPLIT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_sample,
    input  logic                     mode_save,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic signed [COEF_W-1:0] cfg_data,
    output logic                     out_valid,
    output logic signed [IN_W-1:0]   out_sample
);

    localparam int unsigned CF      = COEF_W - 2;
    localparam int unsigned YF      = ST_W - IN_W;
    localparam int unsigned PROD_W  = ST_W + COEF_W;
    localparam int unsigned ACC_W   = PROD_W + 3;
    localparam int unsigned TAP_W   = $clog2(TAP_COUNT);
    localparam int unsigned LATENCY = TAP_COUNT + 1;

    iir2_state_e state, state_nx;

    logic [TAP_W-1:0]          tap;
    logic signed [IN_W-1:0]    x_cur, x1, x2;
    logic signed [ST_W-1:0]    y1, y2;
    logic signed [ACC_W-1:0]   acc, acc_sum;
    logic [CF-1:0]             resid;
    logic                      mode_q;
    logic                      accept;

    logic [TAP_COUNT*COEF_W-1:0] coef_flat;
    logic signed [COEF_W-1:0]    coef_arr [TAP_COUNT];
    logic signed [COEF_W-1:0]    coef_sel;
    logic signed [ST_W-1:0]      op_sel;
    logic                        op_sub;

    logic signed [ST_W-1:0]      q_state;
    logic [CF-1:0]               q_resid;
    logic                        q_sat;

    iir2_coef_bank #(
        .COEF_W (COEF_W),
        .N      (TAP_COUNT),
        .AW     (CFG_AW)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_data),
        .coef_flat (coef_flat)
    );

    for (genvar g = 0; g < TAP_COUNT; g++) begin : g_unpack
        assign coef_arr[g] = coef_flat[g*COEF_W +: COEF_W];
    end

    // operand and coefficient steering for the current tap
    always_comb begin
        op_sel   = '0;
        coef_sel = '0;
        op_sub   = 1'b0;
        case (tap)
            TAP_W'(0): begin op_sel = {x_cur, {YF{1'b0}}}; coef_sel = coef_arr[0]; end
            TAP_W'(1): begin op_sel = {x1, {YF{1'b0}}};    coef_sel = coef_arr[1]; end
            TAP_W'(2): begin op_sel = {x2, {YF{1'b0}}};    coef_sel = coef_arr[2]; end
            TAP_W'(3): begin op_sel = y1; coef_sel = coef_arr[TAP_FB0];     op_sub = 1'b1; end
            TAP_W'(4): begin op_sel = y2; coef_sel = coef_arr[TAP_FB0 + 1]; op_sub = 1'b1; end
            default:   begin op_sel = '0; coef_sel = '0; op_sub = 1'b0; end
        endcase
    end

    iir2_mac #(
        .OP_W      (ST_W),
        .COEF_W    (COEF_W),
        .ACC_W     (ACC_W),
        .MUL_SPLIT (MUL_SPLIT)
    ) u_mac (
        .operand  (op_sel),
        .coef     (coef_sel),
        .subtract (op_sub),
        .acc_in   (acc),
        .acc_out  (acc_sum)
    );

    iir2_requant #(
        .ACC_W (ACC_W),
        .ST_W  (ST_W),
        .CF    (CF)
    ) u_requant (
        .acc     (acc),
        .state_q (q_state),
        .resid_q (q_resid),
        .sat     (q_sat)
    );

    assign accept = (state == ST_IDLE) && in_valid;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nx = ST_MAC;
            ST_MAC:   if (tap == TAP_W'(TAP_COUNT - 1)) state_nx = ST_QUANT;
            ST_QUANT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            tap        <= '0;
            x_cur      <= '0;
            x1         <= '0;
            x2         <= '0;
            y1         <= '0;
            y2         <= '0;
            acc        <= '0;
            resid      <= '0;
            mode_q     <= 1'b0;
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        x_cur  <= in_sample;
                        mode_q <= mode_save;
                        tap    <= '0;
                        acc    <= mode_save ? {{(ACC_W-CF){1'b0}}, resid} : '0;
                    end
                end
                ST_MAC: begin
                    acc <= acc_sum;
                    tap <= tap + 1'b1;
                end
                ST_QUANT: begin
                    x2         <= x1;
                    x1         <= x_cur;
                    y2         <= y1;
                    y1         <= q_state;
                    resid      <= (mode_q && !q_sat) ? q_resid : '0;
                    out_sample <= q_state[ST_W-1 -: IN_W];
                    out_valid  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/iir2_section_chk.sv
module iir2_section_chk #(
    parameter int unsigned LATENCY = 6,
    parameter int unsigned CF      = 22,
    parameter int unsigned ST_W    = 26
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   accept,
    input logic                   out_valid,
    input logic                   mode_used,
    input logic [CF-1:0]          resid,
    input logic signed [ST_W-1:0] y1
);

    // hist[k] holds the accept flag seen k+1 edges ago
    logic [LATENCY:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[LATENCY-1:0], accept};
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && resid == '0 && y1 == '0));

    a_r8_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == hist[LATENCY]);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        accept |-> (hist[LATENCY-1:0] == '0));

    a_r6_trunc_residue_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !mode_used) |-> (resid == '0));

    a_r4_state_moves_with_output: assert property (@(posedge clk) disable iff (rst)
        !$stable(y1) |-> out_valid);

endmodule

bind iir2_section iir2_section_chk #(
    .LATENCY (LATENCY),
    .CF      (CF),
    .ST_W    (ST_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .out_valid (out_valid),
    .mode_used (mode_q),
    .resid     (resid),
    .y1        (y1)
);

// File: tb/test_iir2_section.sv
module test_iir2_section;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               mode_save = 1'b0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_addr = '0;
    logic signed [23:0] cfg_data = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;

    iir2_section i_iir2_section (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .mode_save  (mode_save),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    longint mc [5] = '{0, 0, 0, 0, 0};
    longint mx1 = 0, mx2 = 0, my1 = 0, my2 = 0, mres = 0;

    // scoreboard queues
    longint exp_q [$];
    int     t_q   [$];
    string  req_q [$];

    localparam longint ST_MAX = 64'sd33554431;
    localparam longint ST_MIN = -64'sd33554432;

    task automatic load(input int addr, input longint val);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = 3'(addr);
        cfg_data = 24'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 5) mc[addr] = val;   // R2: addresses 5..7 have no effect
    endtask

    task automatic send(input logic signed [15:0] x, input bit m, input string req);
        longint xs, acc, q, ex;
        xs  = x;
        acc = (m ? mres : 0)
            + mc[0] * (xs  <<< 10) + mc[1] * (mx1 <<< 10) + mc[2] * (mx2 <<< 10)
            - mc[3] * my1 - mc[4] * my2;
        q = acc >>> 22;
        if (q > ST_MAX) begin
            q = ST_MAX; mres = 0;
        end else if (q < ST_MIN) begin
            q = ST_MIN; mres = 0;
        end else begin
            mres = m ? (acc - (q <<< 22)) : 0;
        end
        mx2 = mx1; mx1 = xs; my2 = my1; my1 = q;
        ex  = q >>> 10;

        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x;
        mode_save = m;
        exp_q.push_back(ex);
        t_q.push_back(cyc);
        req_q.push_back(req);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        // R9: strobe inside the busy window, different sample and mode
        in_valid  = 1'b1;
        in_sample = ~x;
        mode_save = !m;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: unexpected output %0d, expected none", out_sample);
            end else begin
                longint ex;
                int     t0, lat;
                string  rq;
                ex = exp_q.pop_front();
                t0 = t_q.pop_front();
                rq = req_q.pop_front();
                checks++;
                if (longint'(out_sample) != ex) begin
                    fails++;
                    $display("FAIL %s: out_sample %0d, expected %0d", rq, out_sample, ex);
                end
                lat = cyc - t0;
                checks++;
                if (lat != 7) begin
                    fails++;
                    $display("FAIL R8: output %0d cycles after drive, expected 7", lat);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;   // R1
        if (out_valid !== 1'b0 || out_sample !== 16'sd0) begin
            fails++;
            $display("FAIL R1: valid %b sample %0d, expected 0 0", out_valid, out_sample);
        end
        // R1: coefficients cleared, so a sample gives zero
        send(16'sd1234, 1'b1, "R1");

        // R2 / R3: unity pass-through, junk to unused address
        load(0, 4194304);
        load(5, 8388607);
        load(7, -1);
        send(16'sd0,      1'b0, "R2");
        send(16'sd1,      1'b1, "R3");
        send(-16'sd1,     1'b0, "R3");
        send(16'sd32767,  1'b1, "R3");
        send(-16'sd32768, 1'b0, "R3");
        send(16'sd12345,  1'b1, "R2");

        // R7: half gain, floor on odd negatives
        load(0, 2097152);
        send(-16'sd3, 1'b0, "R7");
        send(16'sd5,  1'b0, "R7");
        send(-16'sd1, 1'b1, "R7");

        // R4 / R5: resonant low-pass, impulse in saving mode
        load(0, 1048576);
        load(1, 2097152);
        load(2, 1048576);
        load(3, -6710886);
        load(4, 3355443);
        send(16'sd30000, 1'b1, "R5");
        for (int i = 0; i < 40; i++) send(16'sd0, 1'b1, "R5");

        // R6: same impulse, truncation
        send(16'sd30000, 1'b0, "R6");
        for (int i = 0; i < 40; i++) send(16'sd0, 1'b0, "R4");

        // R10: step with DC gain five overruns the state range
        for (int i = 0; i < 30; i++) send(16'sd20000, 1'b1, "R10");
        for (int i = 0; i < 30; i++) send(-16'sd20000, 1'b1, "R10");
        for (int i = 0; i < 30; i++) send(16'sd0, 1'(i % 2), "R6");

        // high-Q band-pass, both modes
        load(0, 20972);
        load(1, 0);
        load(2, -20972);
        load(3, -8304722);
        load(4, 4110837);
        send(16'sd30000, 1'b1, "R5");
        for (int i = 0; i < 60; i++) send(16'sd0, 1'b1, "R5");
        send(-16'sd30000, 1'b0, "R6");
        for (int i = 0; i < 60; i++) send(16'sd0, 1'b0, "R6");

        repeat (10) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d outputs missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule